// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out, for every pin of a general-purpose I/O port, the value that the port's input-data view reports. Each pin is configured by a mode code, an output-type bit (push-pull or open-drain), a pull code and an output-data bit. The pin can also carry an external driver, which is either disconnected or connected and driving a level. The block combines these into one resolved level per pin. A pin whose level cannot be determined (floating) keeps the value it showed before.

External drive requests arrive one at a time as a pin index, a level and a valid strobe. A request that would fight an active output is refused and raises a sticky error flag. A driver that is already connected is dropped as soon as the pin's configuration turns it into a conflict. A separate mask input disconnects any set of pins in one cycle. Every pin whose determined level changes produces a one-cycle rise or fall event, which a parent can use as an edge-sensitive interrupt source.

Top module: `pin_level_resolver`

## Requirements
- R1: During and right after a synchronous reset, every external driver is disconnected, `drv_err` is 0 and both event vectors are 0. `pin_in` shows the level resolved from the configuration present at reset, and a pin that resolves to floating reads 0.
- R2: Encodings per pin i. The mode field is `cfg_mode[2i+1:2i]`: 01 is output, and 00, 10 and 11 all behave as input. The pull field is `cfg_pull[2i+1:2i]`: 01 pulls up, 10 pulls down, and 00 and 11 mean no pull. `cfg_otype[i]` = 1 selects open-drain and 0 selects push-pull.
- R3: An output pin that is push-pull, or open-drain with `out_data` bit 0, shows its `out_data` bit.
- R4: An open-drain output pin with `out_data` bit 1 resolves in this priority order: a connected driver at level 0 gives 0; else pull-up gives 1; else pull-down gives 0; else the pin holds its previous value.
- R5: An input pin with a connected driver shows the driver's level.
- R6: A disconnected input pin shows 1 with pull-up and 0 with pull-down, and holds its previous value with no pull.
- R7: A drive request to an output pin is refused unless the pin is open-drain and the requested level is 0. A refused request leaves the driver state unchanged and sets `drv_err`, which stays 1 until reset.
- R8: A connected driver on an output pin that is push-pull, or that is driving 1, is disconnected in the same cycle in which the configuration creates the conflict. A driver at 0 on an open-drain output stays connected.
- R9: `disc_valid` with `disc_mask` disconnects every masked pin. If an accepted drive request targets a masked pin in the same cycle, the drive request wins.
- R10: For each pin whose level is determined, `rise_evt` pulses for one cycle on a 0 to 1 change and `fall_evt` pulses for one cycle on a 1 to 0 change. Held (floating) pins produce no events.
- R11: `pin_in` and the event vectors change at the first rising clock edge that samples the causing input, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2*NUM_PINS | Mode code per pin, 2 bits each |
| cfg_otype | input | NUM_PINS | Output type per pin: 1 open-drain, 0 push-pull |
| cfg_pull | input | 2*NUM_PINS | Pull code per pin, 2 bits each |
| out_data | input | NUM_PINS | Output-data bit per pin |
| drv_valid | input | 1 | External drive request strobe |
| drv_pin | input | PIN_IDX_W | Pin index of the drive request |
| drv_level | input | 1 | Level of the drive request |
| disc_valid | input | 1 | Disconnect strobe |
| disc_mask | input | NUM_PINS | Pins to disconnect when `disc_valid` is 1 |
| pin_in | output | NUM_PINS | Resolved input level per pin |
| rise_evt | output | NUM_PINS | One-cycle pulse on a determined 0 to 1 change |
| fall_evt | output | NUM_PINS | One-cycle pulse on a determined 1 to 0 change |
| drv_err | output | 1 | Sticky flag for a refused drive request |

## Verification
Input pins are driven high and low, then released under each pull code. This separates driver-follows from pull-resolves from hold-when-floating, and shows that pull code 11 acts as no pull. Open-drain pins step through the full priority chain: driver low, pull-up, pull-down and none. Push-pull pins check that a refused request neither changes the level nor clears the error. Mode changes on connected pins separate an automatic disconnect, which is seen as a held or pulled level on return to input, from a surviving low driver on an open-drain pin. Same-cycle drive and disconnect on one pin, and a multi-pin disconnect, check the priority rule and simultaneous events.

// File: rtl/pinres_pkg.sv
package pinres_pkg;

    typedef enum logic [1:0] {
        MODE_INPUT  = 2'b00,
        MODE_OUTPUT = 2'b01,
        MODE_ALTFN  = 2'b10,
        MODE_ANALOG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DOWN = 2'b10,
        PULL_RESV = 2'b11
    } pull_e;

    // Decoded per-pin configuration
    typedef struct packed {
        logic  is_output;
        logic  open_drain;
        pull_e pull;
        logic  odata;
    } pin_cfg_t;

    // External driver state of one pin
    typedef struct packed {
        logic connected;
        logic level;
    } ext_drv_t;

    // Resolution result: known=0 means the pin floats and holds
    typedef struct packed {
        logic known;
        logic level;
    } pin_res_t;

    function automatic pin_cfg_t make_cfg(logic [1:0] mode, logic otype,
                                          logic [1:0] pull, logic odata);
        pin_cfg_t c;
        c.is_output  = (pin_mode_e'(mode) == MODE_OUTPUT);
        c.open_drain = otype;
        c.pull       = pull_e'(pull);
        c.odata      = odata;
        return c;
    endfunction

    // True when an external drive at 'level' would fight the output
    function automatic logic drive_conflicts(logic is_output, logic open_drain,
                                             logic level);
        return is_output && !(open_drain && !level);
    endfunction

    function automatic pin_res_t resolve_pin(pin_cfg_t c, ext_drv_t d);
        pin_res_t r;
        r.known = 1'b1;
        r.level = c.odata;
        if (c.is_output) begin
            if (c.open_drain && c.odata) begin
                if (d.connected && !d.level) begin
                    r.level = 1'b0;
                end else if (c.pull == PULL_UP) begin
                    r.level = 1'b1;
                end else if (c.pull == PULL_DOWN) begin
                    r.level = 1'b0;
                end else begin
                    r.known = 1'b0;
                end
            end
        end else if (d.connected) begin
            r.level = d.level;
        end else if (c.pull == PULL_UP) begin
            r.level = 1'b1;
        end else if (c.pull == PULL_DOWN) begin
            r.level = 1'b0;
        end else begin
            r.known = 1'b0;
            r.level = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/pinres_drive_ctl.sv
module pinres_drive_ctl
    import pinres_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PINS-1:0]            out_mask,
    input  logic [NUM_PINS-1:0]            od_mask,
    input  logic                           drv_valid,
    input  logic [PIN_IDX_W-1:0]           drv_pin,
    input  logic                           drv_level,
    input  logic                           disc_valid,
    input  logic [NUM_PINS-1:0]            disc_mask,
    output ext_drv_t [NUM_PINS-1:0]        drv_next,
    output logic                           drv_err
);

    ext_drv_t [NUM_PINS-1:0] drv_q;
    logic                    err_q;
    logic                    req_in_range;
    logic                    req_conflict;
    logic                    req_accept;

    // Classify the incoming request against its target pin
    always_comb begin
        req_in_range = 1'b0;
        req_conflict = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (drv_pin == PIN_IDX_W'(i)) begin
                req_in_range = 1'b1;
                req_conflict = drive_conflicts(out_mask[i], od_mask[i], drv_level);
            end
        end
        req_accept = drv_valid && req_in_range && !req_conflict;
    end

    // Next driver state: disconnect, then accepted request, then conflict drop
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            ext_drv_t nxt;
            nxt = drv_q[i];
            if (disc_valid && disc_mask[i]) begin
                nxt.connected = 1'b0;
            end
            if (req_accept && (drv_pin == PIN_IDX_W'(i))) begin
                nxt.connected = 1'b1;
                nxt.level     = drv_level;
            end
            if (nxt.connected && drive_conflicts(out_mask[i], od_mask[i], nxt.level)) begin
                nxt.connected = 1'b0;
            end
            drv_next[i] = rst ? '0 : nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
            err_q <= 1'b0;
        end else begin
            drv_q <= drv_next;
            err_q <= err_q | (drv_valid && req_in_range && req_conflict);
        end
    end

    assign drv_err = err_q;

endmodule

// File: rtl/pinres_pin_eval.sv
module pinres_pin_eval
    import pinres_pkg::*;
(
    input  pin_cfg_t cfg,
    input  ext_drv_t drv,
    output pin_res_t res
);

    always_comb begin
        res = resolve_pin(cfg, drv);
    end

endmodule

// File: rtl/pinres_input_reg.sv
module pinres_input_reg
    import pinres_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pin_res_t [NUM_PINS-1:0] res,
    output logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     rise_evt,
    output logic [NUM_PINS-1:0]     fall_evt
);

    logic [NUM_PINS-1:0] level_q;
    logic [NUM_PINS-1:0] rise_q;
    logic [NUM_PINS-1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                level_q[i] <= res[i].known & res[i].level;
            end
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (res[i].known) begin
                    level_q[i] <= res[i].level;
                    rise_q[i]  <= res[i].level & ~level_q[i];
                    fall_q[i]  <= ~res[i].level & level_q[i];
                end else begin
                    rise_q[i] <= 1'b0;
                    fall_q[i] <= 1'b0;
                end
            end
        end
    end

    assign pin_in   = level_q;
    assign rise_evt = rise_q;
    assign fall_evt = fall_q;

endmodule

// File: rtl/pin_level_resolver.sv
module pin_level_resolver
    import pinres_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2*NUM_PINS-1:0]   cfg_mode,
    input  logic [NUM_PINS-1:0]     cfg_otype,
    input  logic [2*NUM_PINS-1:0]   cfg_pull,
    input  logic [NUM_PINS-1:0]     out_data,
    input  logic                    drv_valid,
    input  logic [PIN_IDX_W-1:0]    drv_pin,
    input  logic                    drv_level,
    input  logic                    disc_valid,
    input  logic [NUM_PINS-1:0]     disc_mask,
    output logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     rise_evt,
    output logic [NUM_PINS-1:0]     fall_evt,
    output logic                    drv_err
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic     [NUM_PINS-1:0] out_mask;
    logic     [NUM_PINS-1:0] od_mask;
    ext_drv_t [NUM_PINS-1:0] drv_next;
    pin_res_t [NUM_PINS-1:0] res;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign cfg[g]      = make_cfg(cfg_mode[2*g +: 2], cfg_otype[g],
                                      cfg_pull[2*g +: 2], out_data[g]);
        assign out_mask[g] = cfg[g].is_output;
        assign od_mask[g]  = cfg[g].open_drain;

        pinres_pin_eval u_eval (
            .cfg (cfg[g]),
            .drv (drv_next[g]),
            .res (res[g])
        );
    end

    pinres_drive_ctl #(.NUM_PINS(NUM_PINS)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .out_mask   (out_mask),
        .od_mask    (od_mask),
        .drv_valid  (drv_valid),
        .drv_pin    (drv_pin),
        .drv_level  (drv_level),
        .disc_valid (disc_valid),
        .disc_mask  (disc_mask),
        .drv_next   (drv_next),
        .drv_err    (drv_err)
    );

    pinres_input_reg #(.NUM_PINS(NUM_PINS)) u_inreg (
        .clk      (clk),
        .rst      (rst),
        .res      (res),
        .pin_in   (pin_in),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

endmodule

// File: rtl/pinres_checker.sv
module pinres_checker #(
    parameter int NUM_PINS = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2*NUM_PINS-1:0] cfg_mode,
    input logic [NUM_PINS-1:0]   cfg_otype,
    input logic [NUM_PINS-1:0]   out_data,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic [NUM_PINS-1:0]   rise_evt,
    input logic [NUM_PINS-1:0]   fall_evt,
    input logic                  drv_err
);

    logic [NUM_PINS-1:0] follow_mask;
    logic                run_seen;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            follow_mask[i] = (cfg_mode[2*i +: 2] == 2'b01) &&
                             (!cfg_otype[i] || !out_data[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_seen <= 1'b0;
        else     run_seen <= 1'b1;
    end

    // R3: driven outputs show their data bit one edge later
    a_r3_output_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_in ^ $past(out_data)) & $past(follow_mask)) == '0));

    // R7: error flag never clears outside reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        drv_err |=> drv_err);

    // R10: rise and fall never together
    a_r10_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        (rise_evt & fall_evt) == '0);

    // R10: a rise event marks a 0 to 1 change
    a_r10_rise_is_edge: assert property (@(posedge clk) disable iff (rst)
        (run_seen && rise_evt != '0) |->
            (((pin_in & rise_evt) == rise_evt) && (($past(pin_in) & rise_evt) == '0)));

    // R10: a fall event marks a 1 to 0 change
    a_r10_fall_is_edge: assert property (@(posedge clk) disable iff (rst)
        (run_seen && fall_evt != '0) |->
            (((pin_in & fall_evt) == '0) && (($past(pin_in) & fall_evt) == fall_evt)));

    // R10: every level change carries an event
    a_r10_change_flagged: assert property (@(posedge clk) disable iff (rst)
        run_seen |-> ((pin_in ^ $past(pin_in)) == (rise_evt | fall_evt)));

endmodule

bind pin_level_resolver pinres_checker #(.NUM_PINS(NUM_PINS)) u_pinres_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .cfg_otype (cfg_otype),
    .out_data  (out_data),
    .pin_in    (pin_in),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .drv_err   (drv_err)
);

// File: tb/test_pin_level_resolver.sv
module test_pin_level_resolver;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2*N-1:0] cfg_mode  = '0;
    logic [N-1:0]   cfg_otype = '0;
    logic [2*N-1:0] cfg_pull  = '0;
    logic [N-1:0]   out_data  = '0;
    logic           drv_valid = 1'b0;
    logic [3:0]     drv_pin   = '0;
    logic           drv_level = 1'b0;
    logic           disc_valid = 1'b0;
    logic [N-1:0]   disc_mask = '0;
    logic [N-1:0]   pin_in, rise_evt, fall_evt;
    logic           drv_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pin_level_resolver #(.NUM_PINS(N)) i_pin_level_resolver (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
        .cfg_pull(cfg_pull), .out_data(out_data), .drv_valid(drv_valid),
        .drv_pin(drv_pin), .drv_level(drv_level), .disc_valid(disc_valid),
        .disc_mask(disc_mask), .pin_in(pin_in), .rise_evt(rise_evt),
        .fall_evt(fall_evt), .drv_err(drv_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input int p, input logic [1:0] m);
        cfg_mode[2*p +: 2] = m;
    endtask

    task automatic set_pull(input int p, input logic [1:0] v);
        cfg_pull[2*p +: 2] = v;
    endtask

    task automatic drive(input int p, input logic lvl);
        drv_valid = 1'b1;
        drv_pin   = 4'(p);
        drv_level = lvl;
        step();
        drv_valid = 1'b0;
    endtask

    task automatic release_pins(input logic [N-1:0] m);
        disc_valid = 1'b1;
        disc_mask  = m;
        step();
        disc_valid = 1'b0;
        disc_mask  = '0;
    endtask

    task automatic t_reset();
        set_mode(2, 2'b01);
        out_data[2] = 1'b1;
        set_pull(0, 2'b01);
        set_pull(1, 2'b10);
        rst = 1'b1;
        repeat (5) step();
        rst = 1'b0;
        check("R1 pin_in after reset", pin_in, 16'h0005);
        check("R1 rise after reset", rise_evt, '0);
        check("R1 fall after reset", fall_evt, '0);
        check("R1 err after reset", {15'd0, drv_err}, 16'd0);
        step();
        check("R1 pin_in steady", pin_in, 16'h0005);
    endtask

    task automatic t_input_drive();
        drv_valid = 1'b1; drv_pin = 4'd3; drv_level = 1'b1;
        #1;
        check("R11 no change before edge", {15'd0, pin_in[3]}, 16'd0);
        step();
        drv_valid = 1'b0;
        check("R5 pin3 follows high", {15'd0, pin_in[3]}, 16'd1);
        check("R10 rise pin3", rise_evt, 16'h0008);
        step();
        check("R10 rise is one cycle", rise_evt, '0);
        drive(3, 1'b0);
        check("R5 pin3 follows low", {15'd0, pin_in[3]}, 16'd0);
        check("R10 fall pin3", fall_evt, 16'h0008);
    endtask

    task automatic t_float_hold();
        release_pins(16'h0008);
        check("R6 float holds 0", {15'd0, pin_in[3]}, 16'd0);
        drive(3, 1'b1);
        release_pins(16'h0008);
        check("R6 float holds 1", {15'd0, pin_in[3]}, 16'd1);
        check("R10 no event on hold", rise_evt | fall_evt, '0);
        set_pull(3, 2'b10);
        step();
        check("R6 pull-down gives 0", {15'd0, pin_in[3]}, 16'd0);
        check("R10 fall on pull-down", fall_evt, 16'h0008);
        set_pull(3, 2'b01);
        step();
        check("R6 pull-up gives 1", {15'd0, pin_in[3]}, 16'd1);
        set_pull(3, 2'b11);
        step();
        check("R2 pull 11 holds", {15'd0, pin_in[3]}, 16'd1);
    endtask

    task automatic t_autodisc();
        drive(9, 1'b0);
        check("R5 pin9 low", {15'd0, pin_in[9]}, 16'd0);
        set_mode(9, 2'b01); out_data[9] = 1'b1;
        step();
        check("R3 pin9 push-pull 1", {15'd0, pin_in[9]}, 16'd1);
        set_mode(9, 2'b00);
        step();
        check("R8 pin9 auto-disconnected holds", {15'd0, pin_in[9]}, 16'd1);
        set_mode(9, 2'b10);
        drive(9, 1'b0);
        check("R2 alt mode acts as input", {15'd0, pin_in[9]}, 16'd0);
        drive(10, 1'b0);
        set_pull(10, 2'b01);
        set_mode(10, 2'b01); cfg_otype[10] = 1'b1; out_data[10] = 1'b1;
        step();
        check("R8 open-drain low driver kept", {15'd0, pin_in[10]}, 16'd0);
        release_pins(16'h0400);
        check("R4 open-drain pull-up after release", {15'd0, pin_in[10]}, 16'd1);
        drive(11, 1'b1);
        check("R5 pin11 high", {15'd0, pin_in[11]}, 16'd1);
        set_pull(11, 2'b10);
        set_mode(11, 2'b01); cfg_otype[11] = 1'b1; out_data[11] = 1'b1;
        step();
        check("R8 high driver dropped on open-drain", {15'd0, pin_in[11]}, 16'd0);
        set_mode(15, 2'b11);
        drive(15, 1'b1);
        check("R2 analog mode acts as input", {15'd0, pin_in[15]}, 16'd1);
    endtask

    task automatic t_priority();
        set_pull(12, 2'b10);
        drv_valid = 1'b1; drv_pin = 4'd12; drv_level = 1'b1;
        disc_valid = 1'b1; disc_mask = 16'h1000;
        step();
        drv_valid = 1'b0; disc_valid = 1'b0; disc_mask = '0;
        check("R9 drive beats disconnect", {15'd0, pin_in[12]}, 16'd1);
        release_pins(16'h1000);
        check("R9 disconnect alone", {15'd0, pin_in[12]}, 16'd0);
        drive(13, 1'b1);
        drive(14, 1'b1);
        set_pull(13, 2'b10);
        set_pull(14, 2'b10);
        step();
        check("R5 drivers override pull", pin_in & 16'h6000, 16'h6000);
        release_pins(16'h6000);
        check("R9 multi-pin disconnect", pin_in & 16'h6000, 16'h0000);
        check("R10 multi-pin fall", fall_evt, 16'h6000);
        check("R7 no error so far", {15'd0, drv_err}, 16'd0);
    endtask

    task automatic t_pushpull();
        set_mode(5, 2'b01); out_data[5] = 1'b1;
        step();
        check("R3 pin5 shows data 1", {15'd0, pin_in[5]}, 16'd1);
        drive(5, 1'b0);
        check("R7 refused drive keeps level", {15'd0, pin_in[5]}, 16'd1);
        check("R7 refused drive sets err", {15'd0, drv_err}, 16'd1);
        out_data[5] = 1'b0;
        step();
        check("R3 pin5 shows data 0", {15'd0, pin_in[5]}, 16'd0);
        repeat (3) step();
        check("R7 err sticky", {15'd0, drv_err}, 16'd1);
    endtask

    task automatic t_opendrain();
        set_mode(7, 2'b01); cfg_otype[7] = 1'b1; out_data[7] = 1'b0;
        set_pull(7, 2'b01);
        step();
        check("R3 open-drain data 0", {15'd0, pin_in[7]}, 16'd0);
        out_data[7] = 1'b1;
        step();
        check("R4 open-drain pull-up", {15'd0, pin_in[7]}, 16'd1);
        drive(7, 1'b0);
        check("R4 low driver wins", {15'd0, pin_in[7]}, 16'd0);
        drive(7, 1'b1);
        check("R7 high drive refused, low kept", {15'd0, pin_in[7]}, 16'd0);
        set_pull(7, 2'b10);
        release_pins(16'h0080);
        check("R4 open-drain pull-down", {15'd0, pin_in[7]}, 16'd0);
        set_pull(7, 2'b01);
        step();
        check("R4 pull-up again", {15'd0, pin_in[7]}, 16'd1);
        set_pull(7, 2'b00);
        step();
        check("R4 no pull holds", {15'd0, pin_in[7]}, 16'd1);
        set_pull(7, 2'b10);
        step();
        check("R4 pull-down after hold", {15'd0, pin_in[7]}, 16'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_input_drive();
        t_float_hold();
        t_autodisc();
        t_priority();
        t_pushpull();
        t_opendrain();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule